// File: doc/BRIEF.md
# Timer Capture/Compare PWM Channel

This block is one channel of a 16-bit timer. It does not own the counter. A shared free-running counter value and a one-cycle overflow strobe come in from outside, and the counter advances by one per clock. The channel holds a 16-bit channel register. Software reaches that register over an 8-bit bus, with one strobe per byte and a single select line that picks the high or the low byte.

With mode code 00 the channel captures. Its input pin passes through a two-flop synchronizer and an edge detector, and on a chosen edge the current counter value is loaded into the channel register. With any other mode code the channel compares. When the counter equals the register, the output pin is toggled, cleared or set. When toggle-on-overflow is enabled together with a clear or set action, the channel produces PWM. Overflow starts each period at the active level, and the compare match ends the active phase. A max-duty request can force a constant active level, but only in the clear-on-compare polarity. The request is taken only at a period boundary. A channel flag records each capture or compare event. Software clears it with a read-then-clear sequence.

Three small state machines do the work:
- **Byte-access machine** (`ACC_OPEN`, `ACC_RD_HOLD`, `ACC_WR_HOLD`). It takes *hold-read* on a high-byte read in capture mode and *hold-write* on a high-byte write in compare mode. It takes *release* on the matching low-byte access.
- **Pin machine** (`OUT_LOW`, `OUT_HIGH`, `OUT_MAX`). Its transitions are *period-start* on overflow, *period-end* on a PWM match, *compare-action* in plain compare mode, *force-enter* when overflow coincides with an accepted max request, and *force-leave* on an overflow without the request or when the PWM setup is left.
- **Flag machine** (`FLG_CLEAR`, `FLG_SET`, `FLG_ARMED`). Its transitions are *event*, *arm* on a status read while set, and *clear* on a clear strobe while armed.

Top module: `tmr_chan`

## Requirements
- R1: After reset `chan_pin` is 0 and `chan_flag` is 0.
- R2: With `bus_hi`=1 the bus reaches register bits 15:8, and with `bus_hi`=0 it reaches bits 7:0. `bus_rdata` shows the selected byte in the same cycle, and a write takes effect at the next clock edge.
- R3: In capture mode (`cfg_mode`=00), `cfg_edge` selects the edge: 00 none, 01 rising, 10 falling, 11 both. A selected edge on `cap_in` loads the counter value into the register within three clock edges. An unselected edge leaves the register unchanged.
- R4: In capture mode, a high-byte read blocks captures until a low-byte read, so the two byte reads return one coherent value.
- R5: In compare mode (`cfg_mode`≠00, not PWM), a clock edge on which the counter equals the register applies `cfg_act` to the pin: 00 none, 01 toggle, 10 drive 0, 11 drive 1. The pin changes at that same edge.
- R6: In compare mode, a high-byte write blocks matches, for both pin and flag, until a low-byte write.
- R7: PWM runs in compare mode with `cfg_tov`=1 and `cfg_act` 10 or 11. Overflow drives the active level (1 for 10, 0 for 11) and a match drives the inactive level. Overflow wins when both come on the same edge, so the pin is active exactly while the counter is at or below the register.
- R8: With `cfg_act`=10 in PWM, `cfg_max` is sampled at overflow. From the next period the pin stays constant 1 and matches are ignored. After `cfg_max` is cleared, the pin stays 1 until the following overflow.
- R9: `chan_flag` sets on each capture or unblocked compare match. It clears only when `flag_clr` follows a `flag_rd` taken while the flag was set. A clear strobe with no prior read has no effect.
- R10: With `cfg_act`=11 in PWM, `cfg_max` has no effect and the inverted PWM waveform continues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_val | input | CW | Shared counter value |
| cnt_ovf | input | 1 | Counter overflow strobe, high on the last count of a period |
| cfg_mode | input | 2 | 00 capture, other values compare |
| cfg_edge | input | 2 | Capture edge select |
| cfg_act | input | 2 | Compare action and PWM polarity |
| cfg_tov | input | 1 | Toggle-on-overflow enable (PWM) |
| cfg_max | input | 1 | Max-duty request |
| bus_wr | input | 1 | Byte write strobe |
| bus_rd | input | 1 | Byte read strobe |
| bus_hi | input | 1 | Byte select, 1 = high byte |
| bus_wdata | input | BW | Write data |
| bus_rdata | output | BW | Read data of the selected byte |
| flag_rd | input | 1 | Status read strobe (arms the flag clear) |
| flag_clr | input | 1 | Flag clear strobe (write of 0) |
| cap_in | input | 1 | Asynchronous capture input |
| chan_flag | output | 1 | Channel event flag |
| chan_pin | output | 1 | Channel output pin |

## Verification
The bench uses the default parameters: a 16-bit register split into two 8-bit bytes and a two-stage synchronizer. It drives the counter with a 16-count period, so every duty value from 0 to the tie value 15 comes within reach in short runs, including the overflow-versus-match tie. A held counter makes capture values exact regardless of synchronizer latency. The wide 16-bit range still checks the high byte, because random capture values fill both bytes.

// File: rtl/tmr_chan_pkg.sv
`timescale 1ns/1ps
package tmr_chan_pkg;

    typedef enum logic [1:0] {
        ACC_OPEN    = 2'd0,
        ACC_RD_HOLD = 2'd1,
        ACC_WR_HOLD = 2'd2
    } acc_state_e;

    typedef enum logic [1:0] {
        OUT_LOW  = 2'd0,
        OUT_HIGH = 2'd1,
        OUT_MAX  = 2'd2
    } out_state_e;

    typedef enum logic [1:0] {
        FLG_CLEAR = 2'd0,
        FLG_SET   = 2'd1,
        FLG_ARMED = 2'd2
    } flg_state_e;

    localparam logic [1:0] MODE_CAPTURE = 2'b00;

    localparam logic [1:0] EDGE_NONE = 2'b00;
    localparam logic [1:0] EDGE_RISE = 2'b01;
    localparam logic [1:0] EDGE_FALL = 2'b10;
    localparam logic [1:0] EDGE_BOTH = 2'b11;

    localparam logic [1:0] ACT_NONE   = 2'b00;
    localparam logic [1:0] ACT_TOGGLE = 2'b01;
    localparam logic [1:0] ACT_CLEAR  = 2'b10;
    localparam logic [1:0] ACT_SET    = 2'b11;

endpackage

// File: rtl/tmr_chan_edge.sv
`timescale 1ns/1ps
module tmr_chan_edge
    import tmr_chan_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sig_i,
    input  logic [1:0] sel_i,
    output logic       hit_o
);

    localparam int LAST = SYNC_STAGES - 1;

    logic [LAST:0] sync_q;
    logic          prev_q;
    logic          rise;
    logic          fall;

    // synchronizer chain, one flop per stage
    for (genvar g = 0; g <= LAST; g++) begin : g_sync
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q[g] <= 1'b0;
                else        sync_q[g] <= sig_i;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q[g] <= 1'b0;
                else        sync_q[g] <= sync_q[g-1];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sync_q[LAST];
    end

    assign rise = sync_q[LAST] & ~prev_q;
    assign fall = ~sync_q[LAST] & prev_q;

    always_comb begin
        unique case (sel_i)
            EDGE_RISE: hit_o = rise;
            EDGE_FALL: hit_o = fall;
            EDGE_BOTH: hit_o = rise | fall;
            default:   hit_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/tmr_chan_regs.sv
`timescale 1ns/1ps
module tmr_chan_regs
    import tmr_chan_pkg::*;
#(
    parameter int CW = 16,
    parameter int BW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          is_cap_i,
    input  logic          bus_wr_i,
    input  logic          bus_rd_i,
    input  logic          bus_hi_i,
    input  logic [BW-1:0] wdata_i,
    input  logic          cap_hit_i,
    input  logic [CW-1:0] cnt_i,
    output logic [BW-1:0] rdata_o,
    output logic [CW-1:0] ch_o,
    output logic          cap_evt_o,
    output logic          cmp_en_o
);

    localparam int HI_LSB = CW - BW;

    acc_state_e    acc_q, acc_d;
    logic [CW-1:0] ch_q;
    logic          rd_hi, rd_lo, wr_hi, wr_lo;

    assign rd_hi = bus_rd_i &  bus_hi_i;
    assign rd_lo = bus_rd_i & ~bus_hi_i;
    assign wr_hi = bus_wr_i &  bus_hi_i;
    assign wr_lo = bus_wr_i & ~bus_hi_i;

    // byte-access state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc_q <= ACC_OPEN;
        else        acc_q <= acc_d;
    end

    always_comb begin
        acc_d = acc_q;
        unique case (acc_q)
            ACC_OPEN: begin
                if (is_cap_i && rd_hi)       acc_d = ACC_RD_HOLD;   // hold-read
                else if (!is_cap_i && wr_hi) acc_d = ACC_WR_HOLD;   // hold-write
            end
            ACC_RD_HOLD: if (rd_lo) acc_d = ACC_OPEN;               // release
            ACC_WR_HOLD: if (wr_lo) acc_d = ACC_OPEN;               // release
            default:     acc_d = ACC_OPEN;
        endcase
    end

    // outputs of the access machine
    always_comb begin
        cap_evt_o = is_cap_i && cap_hit_i && (acc_q != ACC_RD_HOLD)
                    && !bus_wr_i && !rd_hi;
        cmp_en_o  = (acc_q != ACC_WR_HOLD);
        rdata_o   = bus_hi_i ? ch_q[CW-1:HI_LSB] : ch_q[BW-1:0];
        ch_o      = ch_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ch_q <= '0;
        end else if (wr_hi) begin
            ch_q[CW-1:HI_LSB] <= wdata_i;
        end else if (wr_lo) begin
            ch_q[BW-1:0] <= wdata_i;
        end else if (cap_evt_o) begin
            ch_q <= cnt_i;
        end
    end

    AST_CAP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_q == ACC_RD_HOLD && !bus_wr_i) |=> $stable(ch_q)); // R4

    AST_CMP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_q == ACC_OPEN && !is_cap_i && wr_hi) |=> !cmp_en_o); // R6

endmodule

// File: rtl/tmr_chan_out.sv
`timescale 1ns/1ps
module tmr_chan_out
    import tmr_chan_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       oc_mode_i,
    input  logic       tov_i,
    input  logic [1:0] act_i,
    input  logic       max_req_i,
    input  logic       ovf_i,
    input  logic       match_i,
    output logic       pin_o
);

    out_state_e st_q, st_d;
    logic       pwm;
    logic       act_hi;
    logic       max_ok;

    assign pwm    = oc_mode_i & tov_i & act_i[1];
    assign act_hi = (act_i == ACT_CLEAR);
    assign max_ok = pwm & act_hi;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= OUT_LOW;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            OUT_MAX: begin
                if (!max_ok)                    st_d = OUT_HIGH;    // force-leave
                else if (ovf_i && !max_req_i)   st_d = OUT_HIGH;    // force-leave
            end
            OUT_LOW, OUT_HIGH: begin
                if (pwm) begin
                    if (ovf_i) begin
                        if (max_ok && max_req_i) st_d = OUT_MAX;    // force-enter
                        else st_d = act_hi ? OUT_HIGH : OUT_LOW;    // period-start
                    end else if (match_i) begin
                        st_d = act_hi ? OUT_LOW : OUT_HIGH;         // period-end
                    end
                end else if (match_i) begin                         // compare-action
                    unique case (act_i)
                        ACT_TOGGLE: st_d = (st_q == OUT_HIGH) ? OUT_LOW : OUT_HIGH;
                        ACT_CLEAR:  st_d = OUT_LOW;
                        ACT_SET:    st_d = OUT_HIGH;
                        default:    st_d = st_q;
                    endcase
                end
            end
            default: st_d = OUT_LOW;
        endcase
    end

    always_comb begin
        pin_o = (st_q != OUT_LOW);
    end

    AST_MAX_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q == OUT_MAX) |-> $past(ovf_i)); // R8

    AST_MAX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == OUT_MAX && !ovf_i && max_ok) |=> (st_q == OUT_MAX)); // R8

    AST_PWM_START: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm && ovf_i && !(max_ok && max_req_i) && st_q != OUT_MAX)
        |=> (pin_o == $past(act_hi))); // R7

endmodule

// File: rtl/tmr_chan_flag.sv
`timescale 1ns/1ps
module tmr_chan_flag
    import tmr_chan_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic evt_i,
    input  logic rd_i,
    input  logic clr_i,
    output logic flag_o
);

    flg_state_e st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= FLG_CLEAR;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            FLG_CLEAR: if (evt_i) st_d = FLG_SET;                  // event
            FLG_SET:   if (!evt_i && rd_i) st_d = FLG_ARMED;       // arm
            FLG_ARMED: begin
                if (evt_i)      st_d = FLG_SET;                    // event
                else if (clr_i) st_d = FLG_CLEAR;                  // clear
            end
            default: st_d = FLG_CLEAR;
        endcase
    end

    always_comb begin
        flag_o = (st_q != FLG_CLEAR);
    end

    AST_FLAG_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        evt_i |=> flag_o); // R9

    AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag_o) |-> $past(st_q == FLG_ARMED && clr_i)); // R9

endmodule

// File: rtl/tmr_chan.sv
`timescale 1ns/1ps
module tmr_chan
    import tmr_chan_pkg::*;
#(
    parameter int CW          = 16,
    parameter int BW          = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] cnt_val,
    input  logic          cnt_ovf,
    input  logic [1:0]    cfg_mode,
    input  logic [1:0]    cfg_edge,
    input  logic [1:0]    cfg_act,
    input  logic          cfg_tov,
    input  logic          cfg_max,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic          bus_hi,
    input  logic [BW-1:0] bus_wdata,
    output logic [BW-1:0] bus_rdata,
    input  logic          flag_rd,
    input  logic          flag_clr,
    input  logic          cap_in,
    output logic          chan_flag,
    output logic          chan_pin
);

    logic          is_cap;
    logic          cap_hit;
    logic          cap_evt;
    logic          cmp_en;
    logic          match;
    logic [CW-1:0] ch_val;

    assign is_cap = (cfg_mode == MODE_CAPTURE);
    assign match  = !is_cap && cmp_en && (cnt_val == ch_val);

    tmr_chan_edge #(.SYNC_STAGES(SYNC_STAGES)) i_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .sig_i (cap_in),
        .sel_i (cfg_edge),
        .hit_o (cap_hit)
    );

    tmr_chan_regs #(.CW(CW), .BW(BW)) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .is_cap_i  (is_cap),
        .bus_wr_i  (bus_wr),
        .bus_rd_i  (bus_rd),
        .bus_hi_i  (bus_hi),
        .wdata_i   (bus_wdata),
        .cap_hit_i (cap_hit),
        .cnt_i     (cnt_val),
        .rdata_o   (bus_rdata),
        .ch_o      (ch_val),
        .cap_evt_o (cap_evt),
        .cmp_en_o  (cmp_en)
    );

    tmr_chan_out i_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .oc_mode_i (!is_cap),
        .tov_i     (cfg_tov),
        .act_i     (cfg_act),
        .max_req_i (cfg_max),
        .ovf_i     (cnt_ovf),
        .match_i   (match),
        .pin_o     (chan_pin)
    );

    tmr_chan_flag i_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt_i  (cap_evt | match),
        .rd_i   (flag_rd),
        .clr_i  (flag_clr),
        .flag_o (chan_flag)
    );

    AST_CAP_ONLY_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        !is_cap |-> !cap_evt); // R3

endmodule

// File: tb/test_tmr_chan.sv
`timescale 1ns/1ps
module test_tmr_chan;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cnt = '0;
    logic [15:0] cnt_max = 16'd15;
    logic        cnt_run = 1'b0;
    logic        cnt_ld = 1'b0;
    logic [15:0] cnt_ldv = '0;
    logic        cnt_ovf;
    logic [1:0]  cfg_mode = 2'b00, cfg_edge = 2'b00, cfg_act = 2'b00;
    logic        cfg_tov = 1'b0, cfg_max = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0, bus_hi = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        flag_rd = 1'b0, flag_clr = 1'b0, cap_in = 1'b0;
    logic        chan_flag, chan_pin;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        if (cnt_ld)       cnt <= cnt_ldv;
        else if (cnt_run) cnt <= (cnt == cnt_max) ? 16'd0 : cnt + 16'd1;
    end
    assign cnt_ovf = cnt_run && (cnt == cnt_max);

    tmr_chan i_tmr_chan (
        .clk(clk), .rst_n(rst_n), .cnt_val(cnt), .cnt_ovf(cnt_ovf),
        .cfg_mode(cfg_mode), .cfg_edge(cfg_edge), .cfg_act(cfg_act),
        .cfg_tov(cfg_tov), .cfg_max(cfg_max),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_hi(bus_hi),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .flag_rd(flag_rd), .flag_clr(flag_clr), .cap_in(cap_in),
        .chan_flag(chan_flag), .chan_pin(chan_pin)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit cap_expected(input logic [1:0] sel, input bit rising);
        return (sel == 2'b01 && rising) || (sel == 2'b10 && !rising) || (sel == 2'b11);
    endfunction

    function automatic bit pwm_expected(input int c, input int duty, input bit pol, input bit full);
        if (full) return 1'b1;
        return pol ? (c <= duty) : !(c <= duty);
    endfunction

    task automatic wr_byte(input bit hi, input logic [7:0] d);
        bus_wr = 1'b1; bus_hi = hi; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_byte(input bit hi, output logic [7:0] d);
        bus_rd = 1'b1; bus_hi = hi;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic rd_reg(output logic [15:0] v);
        logic [7:0] h, l;
        rd_byte(1'b1, h);
        rd_byte(1'b0, l);
        v = {h, l};
    endtask

    task automatic set_cnt(input logic [15:0] v);
        cnt_ld = 1'b1; cnt_ldv = v;
        @(negedge clk);
        cnt_ld = 1'b0;
    endtask

    task automatic wait_cnt(input logic [15:0] v);
        do @(negedge clk); while (cnt != v);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic flag_clear();
        flag_rd = 1'b1; @(negedge clk); flag_rd = 1'b0;
        flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0;
    endtask

    task automatic pwm_setup(input logic [7:0] duty, input logic [1:0] act);
        cfg_mode = 2'b01; cfg_tov = 1'b1; cfg_act = act;
        wr_byte(1'b1, 8'h00);
        wr_byte(1'b0, duty);
        wait_cnt(16'd0);
        wait_cnt(16'd0);
    endtask

    task automatic pwm_span(input int from, input int duty, input bit pol, input bit full, input string req);
        for (int c = from; c <= 15; c++) begin
            chk(chan_pin == pwm_expected(c, duty, pol, full), req, chan_pin, pwm_expected(c, duty, pol, full));
            @(negedge clk);
        end
    endtask

    initial begin
        logic [15:0] v, prev;
        logic [7:0]  b;
        logic        p1;
        void'($urandom(32'd20240611));

        idle(2);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(chan_pin == 1'b0, "R1 pin", chan_pin, 0);
        chk(chan_flag == 1'b0, "R1 flag", chan_flag, 0);

        // R2: byte addressing
        wr_byte(1'b1, 8'h3C);
        wr_byte(1'b0, 8'hA7);
        rd_reg(v);
        chk(v == 16'h3CA7, "R2 byte map", v, 16'h3CA7);

        // R3 / R9: random captures, held counter
        prev = 16'h3CA7;
        for (int i = 0; i < 10; i++) begin
            logic [1:0] sel;
            bit rising, hit;
            sel = 2'($urandom % 4);
            if (i < 4) sel = 2'(i);
            cfg_edge = sel;
            v = 16'($urandom);
            set_cnt(v);
            rising = !cap_in;
            cap_in = !cap_in;
            idle(4);
            hit = cap_expected(sel, rising);
            rd_reg(b == 8'h00 ? v : v);
            chk(v == (hit ? cnt : prev), "R3 capture", v, hit ? cnt : prev);
            chk(chan_flag == hit, "R9 flag on capture", chan_flag, hit);
            if (hit) prev = v;
            if (chan_flag) begin
                if (i == 2 || i == 3) begin
                    flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0;
                    chk(chan_flag == 1'b1, "R9 clear without read", chan_flag, 1);
                end
                flag_clear();
                chk(chan_flag == 1'b0, "R9 read then clear", chan_flag, 0);
            end
        end

        // R4: high-byte read blocks captures
        cfg_edge = 2'b11;
        set_cnt(16'h1234);
        cap_in = !cap_in; idle(4);
        flag_clear();
        rd_byte(1'b1, b);
        chk(b == 8'h12, "R4 high byte", b, 8'h12);
        set_cnt(16'h5678);
        cap_in = !cap_in; idle(4);
        chk(chan_flag == 1'b0, "R4 no capture event", chan_flag, 0);
        rd_byte(1'b0, b);
        chk(b == 8'h34, "R4 coherent low byte", b, 8'h34);
        cap_in = !cap_in; idle(4);
        rd_reg(v);
        chk(v == 16'h5678, "R4 capture resumes", v, 16'h5678);
        flag_clear();
        cfg_edge = 2'b00;

        // R5: compare actions on a running counter
        cnt_max = 16'd15;
        set_cnt(16'd0);
        cnt_run = 1'b1;
        cfg_mode = 2'b01; cfg_tov = 1'b0; cfg_act = 2'b01;
        wr_byte(1'b1, 8'h00);
        wr_byte(1'b0, 8'h06);
        wait_cnt(16'd10);
        p1 = chan_pin;
        wait_cnt(16'd10);
        chk(chan_pin == !p1, "R5 toggle", chan_pin, !p1);
        chk(chan_flag == 1'b1, "R9 flag on compare", chan_flag, 1);
        cfg_act = 2'b11;
        wait_cnt(16'd10);
        chk(chan_pin == 1'b1, "R5 set", chan_pin, 1);
        cfg_act = 2'b10;
        wait_cnt(16'd6);
        chk(chan_pin == 1'b1, "R5 before match", chan_pin, 1);
        @(negedge clk);
        chk(chan_pin == 1'b0, "R5 clear after match", chan_pin, 0);

        // R6: high-byte write blocks compare
        cfg_act = 2'b01;
        wait_cnt(16'd10);
        wr_byte(1'b1, 8'h00);
        flag_clear();
        p1 = chan_pin;
        wait_cnt(16'd10);
        chk(chan_pin == p1, "R6 pin held", chan_pin, p1);
        chk(chan_flag == 1'b0, "R6 no flag", chan_flag, 0);
        wr_byte(1'b0, 8'h06);
        wait_cnt(16'd10);
        chk(chan_pin == !p1, "R6 compare resumes", chan_pin, !p1);

        // R7: directed PWM corners then random duties
        pwm_setup(8'd5, 2'b10);
        pwm_span(0, 5, 1'b1, 1'b0, "R7 duty5 high");
        pwm_setup(8'd0, 2'b10);
        pwm_span(0, 0, 1'b1, 1'b0, "R7 duty0");
        pwm_setup(8'd15, 2'b10);
        pwm_span(0, 15, 1'b1, 1'b0, "R7 tie overflow wins");
        pwm_setup(8'd9, 2'b11);
        pwm_span(0, 9, 1'b0, 1'b0, "R7 inverted");
        for (int i = 0; i < 6; i++) begin
            int d;
            bit pol;
            d = int'($urandom % 16);
            pol = 1'($urandom % 2);
            pwm_setup(8'(d), pol ? 2'b10 : 2'b11);
            pwm_span(0, d, pol, 1'b0, "R7 random");
        end

        // R8: max-duty latency
        pwm_setup(8'd5, 2'b10);
        wait_cnt(16'd2);
        cfg_max = 1'b1;
        pwm_span(2, 5, 1'b1, 1'b0, "R8 same period unchanged");
        pwm_span(0, 5, 1'b1, 1'b1, "R8 forced full");
        wait_cnt(16'd3);
        cfg_max = 1'b0;
        pwm_span(3, 5, 1'b1, 1'b1, "R8 full until boundary");
        pwm_span(0, 5, 1'b1, 1'b0, "R8 normal after release");

        // R10: max request ignored for set-on-compare
        cfg_max = 1'b1;
        pwm_setup(8'd5, 2'b11);
        pwm_span(0, 5, 1'b0, 1'b0, "R10 max ignored");
        pwm_span(0, 5, 1'b0, 1'b0, "R10 max ignored");
        cfg_max = 1'b0;

        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        #750000;
        if (!done) begin
            done = 1'b1;
            total++;
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

endmodule